// File: doc/BRIEF.md
# Padded vertex count calculator

This block takes a vertex count and rounds it up to a padded count whose odd part is 1, 3, 5, 7 or 9 and whose remaining factor is a power of two. Later stages can then split a linear thread index into vertex and instance numbers with one shift and one small fixed divider, instead of dividing by an arbitrary count. The price is a few extra padded threads. This is fewer than rounding to the next power of two would give, because the odd factor follows the leading one and the three bits below it.

A request is one count with a valid strobe. One cycle later the block presents three registered results: the padded count, the shift, and a 3-bit odd-factor code m. The padded count equals (2m+1) shifted left by the shift. Requests may arrive every cycle. When no request arrives, the last result stays on the outputs.

Top module: `vtx_pad_calc`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. Reset forces `out_valid`, `out_padded`, `out_odd` and `out_shift` to zero.
- R2: Every result satisfies `out_padded` = (2·`out_odd`+1)·2^`out_shift`. `out_odd` lies in 0..4, so the odd factor is 1, 3, 5, 7 or 9. The form is normalised: `out_odd` is 0 exactly when `out_padded` is a power of two.
- R3: `out_padded` is strictly greater than the requested count.
- R4: `out_padded` is a multiple of 4.
- R5: For a count of 32 or more, let p be the index of its highest set bit and n = p−3. Let h be the four bits from bit p down to bit n. If h is 1000 the result is 9·2^n. If h is 1001 it is 10·2^n. If h is 1010 or 1011 it is 12·2^n. If h is 1100 or 1101 it is 14·2^n. If h is 1110 or 1111 it is 16·2^n.
- R6: For a count below 32, the result is the next multiple of 4 above the count, 4·(floor(count/4)+1).
- R7: A count of 0 gives a padded count of 4, with `out_odd` = 0 and `out_shift` = 2.
- R8: A count of 70 gives 72, with `out_odd` = 4 and `out_shift` = 3.
- R9: A count whose top three bits are 111 gives 2^W. This value needs the extra output bit, and `out_odd` is then 0 with `out_shift` = W.
- R10: In a cycle without a request, `out_padded`, `out_odd` and `out_shift` keep their previous values, whatever `req_count` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A count is presented this cycle |
| req_count | input | W | Vertex count to pad |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| out_padded | output | W+1 | Padded count |
| out_odd | output | 3 | Odd-factor code m; the odd factor is 2m+1 |
| out_shift | output | $clog2(W+1) | Power-of-two exponent of the padded count |

## Verification
Two things happen at the same clock edge: the result of one request is presented, and the next request is captured. The bench streams requests on every cycle with no gap, so each sample shows the answer to the count driven one cycle earlier while a new count is already on the inputs. Each answer is compared with a value computed arithmetically from the requirement rules for that earlier count. The bench also drops `req_valid` while changing `req_count`, to show that holding the result and accepting no new count do not disturb each other.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  // Class of the three bits that follow the leading one.
  typedef enum logic [2:0] {
    HI_1000,
    HI_1001,
    HI_101X,
    HI_110X,
    HI_111X
  } hi_class_e;

  // Odd code and shift for the small (below 32) path.
  typedef struct packed {
    logic [2:0] m;
    logic [2:0] s;
  } small_fac_t;

  function automatic hi_class_e classify_hi(logic [2:0] tail);
    hi_class_e c;
    casez (tail)
      3'b000:  c = HI_1000;
      3'b001:  c = HI_1001;
      3'b01?:  c = HI_101X;
      3'b10?:  c = HI_110X;
      default: c = HI_111X;
    endcase
    return c;
  endfunction

  // m such that the odd factor is 2m+1
  function automatic logic [2:0] odd_code(hi_class_e c);
    case (c)
      HI_1000: return 3'd4;
      HI_1001: return 3'd2;
      HI_101X: return 3'd1;
      HI_110X: return 3'd3;
      default: return 3'd0;
    endcase
  endfunction

  // Extra shift above n after removing even factors
  function automatic logic [2:0] shift_bump(hi_class_e c);
    case (c)
      HI_1000: return 3'd0;
      HI_1001: return 3'd1;
      HI_101X: return 3'd2;
      HI_110X: return 3'd1;
      default: return 3'd4;
    endcase
  endfunction

  // Next multiple of four above a 5-bit value
  function automatic logic [5:0] small_round(logic [4:0] low);
    return {1'b0, low | 5'b00011} + 6'd1;
  endfunction

  // Split a value of 4..32 into odd code and trailing-zero count
  function automatic small_fac_t small_factor(logic [5:0] v);
    small_fac_t r;
    logic [5:0] t;
    t   = v;
    r.s = 3'd0;
    for (int i = 0; i < 5; i++) begin
      if (t[0] == 1'b0) begin
        t   = t >> 1;
        r.s = r.s + 3'd1;
      end
    end
    r.m = t[3:1];
    return r;
  endfunction

endpackage

// File: rtl/vpc_lead_one.sv
module vpc_lead_one #(
  parameter int W  = 32,
  parameter int PB = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PB-1:0] pos,
  output logic          found
);

  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = PB'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vpc_factor.sv
module vpc_factor
  import vpc_pkg::*;
#(
  parameter int W  = 32,
  parameter int PB = $clog2(W),
  parameter int SW = $clog2(W + 1),
  parameter int PW = W + 1
) (
  input  logic [W-1:0]  count,
  input  logic [PB-1:0] pos,
  input  logic          found,
  output logic [2:0]    m,
  output logic [SW-1:0] s,
  output logic [PW-1:0] padded,
  output logic          small_path
);

  logic [PB-1:0] n;
  logic [2:0]    tail;
  hi_class_e     cls;
  small_fac_t    sf;

  assign small_path = !found || (pos < PB'(5));
  assign n          = pos - PB'(3);
  assign tail       = 3'(count >> n);
  assign cls        = classify_hi(tail);
  assign sf         = small_factor(small_round(count[4:0]));

  always_comb begin
    if (small_path) begin
      m = sf.m;
      s = SW'(sf.s);
    end else begin
      m = odd_code(cls);
      s = SW'(n) + SW'(shift_bump(cls));
    end
  end

  assign padded = PW'({m, 1'b1}) << s;

endmodule

// File: rtl/vtx_pad_calc.sv
module vtx_pad_calc #(
  parameter  int W  = 32,
  localparam int PB = $clog2(W),
  localparam int SW = $clog2(W + 1),
  localparam int PW = W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [W-1:0]  req_count,
  output logic          out_valid,
  output logic [PW-1:0] out_padded,
  output logic [2:0]    out_odd,
  output logic [SW-1:0] out_shift
);

  logic [PB-1:0] lead_pos;
  logic          lead_found;
  logic [2:0]    nxt_odd;
  logic [SW-1:0] nxt_shift;
  logic [PW-1:0] nxt_padded;
  logic          small_path;

  vpc_lead_one #(.W(W), .PB(PB)) u_lead (
    .vec   (req_count),
    .pos   (lead_pos),
    .found (lead_found)
  );

  vpc_factor #(.W(W), .PB(PB), .SW(SW), .PW(PW)) u_fac (
    .count      (req_count),
    .pos        (lead_pos),
    .found      (lead_found),
    .m          (nxt_odd),
    .s          (nxt_shift),
    .padded     (nxt_padded),
    .small_path (small_path)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_padded <= '0;
      out_odd    <= '0;
      out_shift  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_padded <= nxt_padded;
        out_odd    <= nxt_odd;
        out_shift  <= nxt_shift;
      end
    end
  end

endmodule

// File: rtl/vpc_check.sv
module vpc_check #(
  parameter int W  = 32,
  parameter int SW = $clog2(W + 1),
  parameter int PW = W + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [W-1:0]  req_count,
  input logic          out_valid,
  input logic [PW-1:0] out_padded,
  input logic [2:0]    out_odd,
  input logic [SW-1:0] out_shift,
  input logic          small_path
);

  logic [W-1:0] cap_count;
  logic         cap_small;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_count <= '0;
      cap_small <= 1'b0;
    end else if (req_valid) begin
      cap_count <= req_count;
      cap_small <= small_path;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  p_odd_range_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_odd <= 3'd4);

  p_pow2_norm_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (($countones(out_padded) == 1) == (out_odd == 3'd0)));

  p_above_input_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_padded > {1'b0, cap_count});

  p_mult4_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_padded[1:0] == 2'b00);

  p_small_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_small) |-> out_padded == (PW'(cap_count | W'(3)) + PW'(1)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(out_padded) && $stable(out_odd) && $stable(out_shift)));

endmodule

bind vtx_pad_calc vpc_check #(.W(W), .SW(SW), .PW(PW)) u_chk (.*);

// File: tb/sim_vtx_pad_calc.sv
module sim_vtx_pad_calc;
  localparam int W  = 32;
  localparam int PW = W + 1;
  localparam int SW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [W-1:0]  req_count = '0;
  logic          out_valid;
  logic [PW-1:0] out_padded;
  logic [2:0]    out_odd;
  logic [SW-1:0] out_shift;

  int total = 0;
  int bad   = 0;
  bit pend  = 1'b0;
  longint unsigned pend_c = 0;

  always #2 clk = ~clk;

  vtx_pad_calc #(.W(W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_count  (req_count),
    .out_valid  (out_valid),
    .out_padded (out_padded),
    .out_odd    (out_odd),
    .out_shift  (out_shift)
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned exp_pad(longint unsigned c);
    int p;
    int n;
    longint unsigned hi;
    if (c < 32) return ((c / 4) + 1) * 4;
    p = 0;
    for (int i = 0; i < W; i++) if (((c >> i) & 1) == 1) p = i;
    n  = p - 3;
    hi = c >> n;
    case (hi)
      8:       return 64'd9 << n;
      9:       return 64'd10 << n;
      10, 11:  return 64'd12 << n;
      12, 13:  return 64'd14 << n;
      default: return 64'd16 << n;
    endcase
  endfunction

  function automatic longint unsigned exp_s(longint unsigned v);
    longint unsigned s = 0;
    while (v % 2 == 0) begin
      v = v / 2;
      s++;
    end
    return s;
  endfunction

  function automatic string tag_of(longint unsigned c);
    if (c == 0) return "R7";
    if (c == 70) return "R8";
    if ((c >> (W - 3)) == 7) return "R9";
    if (c < 32) return "R6";
    return "R5";
  endfunction

  task automatic verify(longint unsigned c);
    longint unsigned p = exp_pad(c);
    longint unsigned s = exp_s(p);
    longint unsigned m = ((p >> s) - 1) / 2;
    string t = tag_of(c);
    check("R1 valid", longint'(out_valid), 1);
    check({t, " padded"}, longint'(out_padded), p);
    check("R2 odd code", longint'(out_odd), m);
    check("R2 shift", longint'(out_shift), s);
    check("R3 above input", (longint'(out_padded) > c) ? 1 : 0, 1);
    check("R4 multiple of 4", longint'(out_padded) % 4, 0);
  endtask

  task automatic step(bit v, longint unsigned c);
    @(negedge clk);
    if (pend) verify(pend_c);
    req_valid = v;
    req_count = W'(c);
    pend      = v;
    pend_c    = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset padded", longint'(out_padded), 0);
    check("R1 reset odd", longint'(out_odd), 0);
    check("R1 reset shift", longint'(out_shift), 0);
    rst = 1'b0;

    for (int i = 0; i < 4096; i++) step(1'b1, longint'(i));

    for (int p = 5; p < W; p++) begin
      for (int t = 0; t < 8; t++) begin
        for (int f = 0; f < 2; f++) begin
          longint unsigned c = (64'(8 + t)) << (p - 3);
          if (f == 1) c = c | ((64'd1 << (p - 3)) - 1);
          step(1'b1, c);
        end
      end
    end

    step(1'b1, 70);
    step(1'b1, 0);
    step(1'b1, 64'hFFFF_FFFF);
    step(1'b1, 64'h7FFF_FFFF);
    step(1'b1, 64'hE000_0000);
    step(1'b1, 70);
    step(1'b0, 12345);

    // no request: result must stay at 70's answer while req_count changes
    @(negedge clk);
    req_count = W'(999);
    check("R1 idle valid", longint'(out_valid), 0);
    check("R10 hold padded", longint'(out_padded), 72);
    check("R10 hold odd", longint'(out_odd), 4);
    check("R10 hold shift", longint'(out_shift), 3);
    @(negedge clk);
    check("R10 hold padded later", longint'(out_padded), 72);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule